// File: doc/BRIEF.md
# Coarse-to-Fine Motion Search Sequencer

This block steers a block-matching motion search. It sends one candidate displacement at a time to an external SAD unit and waits for the matching cost to return. It also keeps the lowest cost seen so far. The SAD arithmetic and the pixel storage sit outside the block.

A search runs in two passes:

- **Coarse pass.** The block steps through a regular lattice of offsets. The lattice covers the whole ±RANGE window, so a false minimum near the origin cannot trap the search. After the lattice comes one extra candidate: the vector that the co-located block had in the previous frame.
- **Fine pass.** The block tests the four offsets at distance 1 from the best coarse point. It skips any neighbour that was already tested or that lies outside the window.

When the search ends, the block holds the winning vector on its output and raises a single-cycle done pulse.

Top module: `mv_search_seq`

## Requirements
- R1: While reset is held and after it is released, `cand_valid` and `done` are low until a start is accepted.
- R2: After a start, the first 25 candidates are the lattice points with x and y in {-8,-4,0,4,8}. They are issued in row-major order: y is the outer loop from -8 upward, and x is the inner loop from -8 upward.
- R3: The previous-frame vector captured at start is issued right after the lattice. It is issued only when both of its components lie in [-8,8] and it is not a lattice point; otherwise it is skipped.
- R4: A new candidate is never issued while a SAD result is still outstanding. The block waits for `sad_valid` after every candidate.
- R5: The fine pass visits the neighbours of the best coarse point (bx,by) in this order: (bx,by-1), (bx-1,by), (bx+1,by), (bx,by+1).
- R6: A fine neighbour is skipped if it lies outside [-8,8], if it is a lattice point, or if it equals the previous-frame vector when that vector was issued. No candidate outside [-8,8] is ever issued.
- R7: The best candidate is replaced only by a strictly lower SAD. When two SADs are equal, the candidate issued first is kept.
- R8: At the end of the fine pass, `done` is high for exactly one cycle. While it is high, `mv_x`/`mv_y` show the lowest-SAD candidate among all candidates issued in the search.
- R9: A start that arrives while a search is running is ignored. The search in progress is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (accepted only when idle) |
| pred_x | input | VW | Previous-frame vector, x (signed) |
| pred_y | input | VW | Previous-frame vector, y (signed) |
| cand_valid | output | 1 | Candidate offset is valid this cycle |
| cand_x | output | VW | Candidate offset x (signed) |
| cand_y | output | VW | Candidate offset y (signed) |
| sad_valid | input | 1 | SAD result for the last candidate is valid |
| sad_in | input | SADW | SAD result |
| done | output | 1 | Search complete (one-cycle pulse) |
| mv_x | output | VW | Winning vector x (signed) |
| mv_y | output | VW | Winning vector y (signed) |

## Verification
The assertions check, on every cycle, properties that hold for any SAD surface:

- every issued offset and every final vector stays inside the window;
- only one SAD request is outstanding at a time;
- done lasts a single cycle;
- no candidate appears outside a started search.

Other behaviours depend on the values of the costs, so only the bench scenarios can show them. These are the candidate order, the skipping of repeated or lattice neighbours, the handling of the predictor, the tie rule and the correctness of the final vector. The bench checks them with SAD surfaces whose minima sit off-lattice, at the window corner, on the predictor, and on a flat plane.

// File: rtl/mv_search_seq.sv
module mv_search_seq #(
  parameter int RANGE = 8,
  parameter int STEP  = 4,
  parameter int SADW  = 16,
  localparam int VW   = $clog2(RANGE + 1) + 1,
  localparam int NPT  = 2 * RANGE / STEP + 1,
  localparam int NC   = NPT * NPT,
  localparam int IW   = $clog2(NC + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic signed [VW-1:0]   pred_x,
  input  logic signed [VW-1:0]   pred_y,
  output logic                   cand_valid,
  output logic signed [VW-1:0]   cand_x,
  output logic signed [VW-1:0]   cand_y,
  input  logic                   sad_valid,
  input  logic [SADW-1:0]        sad_in,
  output logic                   done,
  output logic signed [VW-1:0]   mv_x,
  output logic signed [VW-1:0]   mv_y
);
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_ADV, S_FIN} st_t;

  st_t                 st;
  logic                fine, pred_used;
  logic [IW-1:0]       idx;
  logic signed [VW-1:0] px, py, ctr_x, ctr_y, best_x, best_y;
  logic [SADW-1:0]     best_sad;
  int                  xi, yi;
  logic                in_rng, on_lat, is_pred, skip, last_coarse;

  always_comb begin
    xi = 0;
    yi = 0;
    if (!fine) begin
      if (int'(idx) < NC) begin
        xi = -RANGE + (int'(idx) % NPT) * STEP;
        yi = -RANGE + (int'(idx) / NPT) * STEP;
      end else begin
        xi = int'(px);
        yi = int'(py);
      end
    end else begin
      case (idx[1:0])
        2'd0:    begin xi = int'(ctr_x);     yi = int'(ctr_y) - 1; end
        2'd1:    begin xi = int'(ctr_x) - 1; yi = int'(ctr_y);     end
        2'd2:    begin xi = int'(ctr_x) + 1; yi = int'(ctr_y);     end
        default: begin xi = int'(ctr_x);     yi = int'(ctr_y) + 1; end
      endcase
    end
  end

  assign last_coarse = !fine && int'(idx) == NC;
  assign in_rng  = xi >= -RANGE && xi <= RANGE && yi >= -RANGE && yi <= RANGE;
  assign on_lat  = ((xi + RANGE) % STEP == 0) && ((yi + RANGE) % STEP == 0);
  assign is_pred = pred_used && xi == int'(px) && yi == int'(py);
  assign skip    = !in_rng || ((fine || last_coarse) && on_lat) || (fine && is_pred);

  assign cand_valid = st == S_ISSUE && !skip;
  assign cand_x     = xi[VW-1:0];
  assign cand_y     = yi[VW-1:0];
  assign done       = st == S_FIN;
  assign mv_x       = best_x;
  assign mv_y       = best_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      fine      <= 1'b0;
      pred_used <= 1'b0;
      idx       <= '0;
      px        <= '0;
      py        <= '0;
      ctr_x     <= '0;
      ctr_y     <= '0;
      best_x    <= '0;
      best_y    <= '0;
      best_sad  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          px        <= pred_x;
          py        <= pred_y;
          fine      <= 1'b0;
          pred_used <= 1'b0;
          idx       <= '0;
          st        <= S_ISSUE;
        end
        S_ISSUE: begin
          if (skip) st <= S_ADV;
          else begin
            if (last_coarse) pred_used <= 1'b1;
            st <= S_WAIT;
          end
        end
        S_WAIT: if (sad_valid) begin
          if ((!fine && idx == '0) || sad_in < best_sad) begin
            best_sad <= sad_in;
            best_x   <= cand_x;
            best_y   <= cand_y;
          end
          st <= S_ADV;
        end
        S_ADV: begin
          if (last_coarse) begin
            fine  <= 1'b1;
            idx   <= '0;
            ctr_x <= best_x;
            ctr_y <= best_y;
            st    <= S_ISSUE;
          end else if (fine && idx == IW'(3)) begin
            st <= S_FIN;
          end else begin
            idx <= idx + 1'b1;
            st  <= S_ISSUE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mv_search_seq_chk.sv
module mv_search_seq_chk #(
  parameter int RANGE = 8,
  parameter int VW    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 cand_valid,
  input logic signed [VW-1:0] cand_x,
  input logic signed [VW-1:0] cand_y,
  input logic                 sad_valid,
  input logic                 done,
  input logic signed [VW-1:0] mv_x,
  input logic signed [VW-1:0] mv_y
);
  logic pend, busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      busy <= 1'b0;
    end else begin
      if (cand_valid) pend <= 1'b1;
      else if (sad_valid) pend <= 1'b0;
      if (done) busy <= 1'b0;
      else if (start) busy <= 1'b1;
    end
  end

  AST_CAND_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (int'(cand_x) >= -RANGE && int'(cand_x) <= RANGE &&
                    int'(cand_y) >= -RANGE && int'(cand_y) <= RANGE)); // R6
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> !pend); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_MV_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(mv_x) >= -RANGE && int'(mv_x) <= RANGE &&
              int'(mv_y) >= -RANGE && int'(mv_y) <= RANGE)); // R8
  AST_NO_CAND_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> busy); // R1
endmodule

bind mv_search_seq mv_search_seq_chk #(.RANGE(RANGE), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .cand_valid(cand_valid),
  .cand_x(cand_x), .cand_y(cand_y), .sad_valid(sad_valid), .done(done),
  .mv_x(mv_x), .mv_y(mv_y)
);

// File: tb/sim_mv_search_seq.sv
`timescale 1ns/1ps
module sim_mv_search_seq;
  localparam int VW = 5;
  logic clk = 0, rst_n = 0, start = 0, sad_valid = 0;
  logic signed [VW-1:0] pred_x = '0, pred_y = '0;
  logic [15:0] sad_in = '0;
  logic cand_valid, done;
  logic signed [VW-1:0] cand_x, cand_y, mv_x, mv_y;

  always #2 clk = ~clk;

  mv_search_seq u0 (.clk(clk), .rst_n(rst_n), .start(start), .pred_x(pred_x), .pred_y(pred_y),
    .cand_valid(cand_valid), .cand_x(cand_x), .cand_y(cand_y), .sad_valid(sad_valid),
    .sad_in(sad_in), .done(done), .mv_x(mv_x), .mv_y(mv_y));

  int total = 0, bad = 0;
  int qx[$], qy[$];
  string qt[$];
  int mode = 0, tx = 0, ty = 0, rc = 0, pend = 0;

  function automatic int iabs(int v); return v < 0 ? -v : v; endfunction
  function automatic int sadf(int x, int y);
    if (mode == 1) return 100;
    return 3 * iabs(x - tx) + 3 * iabs(y - ty) + 10;
  endfunction
  function automatic bit inw(int x, int y);
    return x >= -8 && x <= 8 && y >= -8 && y <= 8;
  endfunction
  function automatic bit lat(int x, int y);
    return inw(x, y) && ((x + 8) % 4 == 0) && ((y + 8) % 4 == 0);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor and SAD responder
  always @(negedge clk) begin
    sad_valid = 0;
    if (rc > 0) begin
      rc--;
      if (rc == 0) begin sad_valid = 1; sad_in = 16'(pend); end
    end
    if (rst_n && cand_valid) begin
      chk(rc == 0, "R4 candidate while SAD outstanding", rc, 0);
      if (qx.size() == 0) chk(0, "R6 unexpected candidate x", int'(cand_x), 99);
      else begin
        automatic int ex = qx.pop_front(), ey = qy.pop_front();
        automatic string t = qt.pop_front();
        chk(int'(cand_x) == ex, {t, " cand_x"}, int'(cand_x), ex);
        chk(int'(cand_y) == ey, {t, " cand_y"}, int'(cand_y), ey);
      end
      pend = sadf(int'(cand_x), int'(cand_y));
      rc = 2;
    end
  end

  task automatic run(int px, int py, int m, int txx, int tyy, bit poke, string tag);
    int bx, by, bs, cx, cy, ex[4], ey[4];
    bit pu;
    mode = m; tx = txx; ty = tyy;
    bs = 0; bx = 0; by = 0; pu = 0;
    for (int yy = -8; yy <= 8; yy += 4)
      for (int xx = -8; xx <= 8; xx += 4) begin
        qx.push_back(xx); qy.push_back(yy); qt.push_back("R2 lattice");
        if ((yy == -8 && xx == -8) || sadf(xx, yy) < bs) begin bs = sadf(xx, yy); bx = xx; by = yy; end
      end
    if (inw(px, py) && !lat(px, py)) begin
      pu = 1;
      qx.push_back(px); qy.push_back(py); qt.push_back("R3 predictor");
      if (sadf(px, py) < bs) begin bs = sadf(px, py); bx = px; by = py; end
    end
    cx = bx; cy = by;
    ex = '{cx, cx - 1, cx + 1, cx}; ey = '{cy - 1, cy, cy, cy + 1};
    for (int k = 0; k < 4; k++) begin
      if (!inw(ex[k], ey[k]) || lat(ex[k], ey[k]) || (pu && ex[k] == px && ey[k] == py)) continue;
      qx.push_back(ex[k]); qy.push_back(ey[k]); qt.push_back("R5 R6 fine");
      if (sadf(ex[k], ey[k]) < bs) begin bs = sadf(ex[k], ey[k]); bx = ex[k]; by = ey[k]; end
    end
    @(negedge clk);
    pred_x = VW'(px); pred_y = VW'(py); start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      repeat (20) @(negedge clk);
      pred_x = 5'sd3; pred_y = 5'sd3; start = 1;
      @(negedge clk);
      start = 0;
    end
    begin
      int w = 0;
      while (!done && w < 2000) begin @(negedge clk); w++; end
      chk(w < 2000, {"R8 watchdog ", tag}, w, 0);
    end
    chk(int'(mv_x) == bx, {"R8 mv_x ", tag}, int'(mv_x), bx);
    chk(int'(mv_y) == by, {"R8 mv_y ", tag}, int'(mv_y), by);
    chk(qx.size() == 0, {"R6 missing candidates ", tag}, qx.size(), 0);
    @(negedge clk);
    chk(!done, {"R8 done single cycle ", tag}, int'(done), 0);
    qx.delete(); qy.delete(); qt.delete();
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cand_valid, "R1 cand_valid in reset", int'(cand_valid), 0);
    chk(!done, "R1 done in reset", int'(done), 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!cand_valid && !done, "R1 idle after reset", int'(cand_valid), 0);
    run(0, 0, 0, 5, -3, 0, "off-lattice target");
    run(5, -3, 0, 5, -3, 0, "predictor hit");
    run(12, 0, 0, 8, 8, 0, "corner, predictor out of range");
    run(1, 0, 0, 0, 0, 0, "R6 neighbour equals predictor");
    run(2, 2, 1, 0, 0, 0, "R7 flat surface ties");
    run(-6, 7, 0, -7, 6, 1, "R9 start while busy");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule